// File: doc/BRIEF.md
# Binary Geodesic Reconstruction Cell Array

This block holds one single-bit cell per pixel of a small binary image and grows a wave from seed pixels through the connected foreground of a mask image. A one-cycle start pulse clears every cell and captures the mask and seed images. From then on, each advance is one neighbour hop over the whole array. A cell turns on when its mask pixel is 1 and it is seeded or has an enabled neighbour that is on. Propagation stops when an advance changes nothing. The block then raises a completion flag and holds the reconstructed image on its output, together with the number of advances that changed at least one cell.

The block has two advance modes. In free-running mode it advances on every clock. In stepped mode it advances only on clocks where a step strobe is high. Four enable bits gate propagation arriving from each compass direction.

A hole-fill option inverts the captured mask and seeds every border cell. The wave then reconstructs the background that touches the edge. The output is the complement of that background: objects with their enclosed holes filled. Images are flattened row-major. Bit `r*COLS + c` is row `r`, column `c`, and row 0 is the top row.

Top module: `geo_recon_array`

## Requirements
- R1: After reset, `image_o` is all zero, `done_o` is 0 and `iter_o` is 0.
- R2: A cycle with `start_i` high clears all cells, captures the mask and seed images, clears `done_o` and `iter_o`, and enters the running phase. In normal mode, `image_o` is all zero in the following cycle.
- R3: On each advance, a cell that is off turns on exactly when its captured mask bit is 1 and either its seed bit is 1 or at least one enabled neighbour was on before the advance.
- R4: A seed bit placed on a cell whose mask bit is 0 has no effect: that cell stays off and starts no wave.
- R5: A cell that is on stays on until the next start. Each cell switches at most once per operation.
- R6: Positions outside the array count as off. A wave never wraps from one edge to the opposite edge.
- R7: `dir_en_i` gates propagation by the direction it arrives from: bit 0 from the north neighbour (row r-1), bit 1 from the south (row r+1), bit 2 from the west (column c-1), bit 3 from the east (column c+1). The gates are sampled live on each advance.
- R8: With `free_run_i` low, the array advances only on cycles where `step_i` is high. Otherwise the cells and `iter_o` hold.
- R9: With `free_run_i` high, the array advances on every clock of the running phase.
- R10: The first advance that changes no cell ends the running phase. `done_o` is 1 from the next cycle on. `iter_o` then equals the number of advances that changed at least one cell, and it holds until the next start.
- R11: With `fill_holes_i` high at start, the mask is inverted and every border cell is seeded. `image_o` shows the complement of the cell states, so the final image is the objects with their enclosed holes filled.
- R12: A start that falls in the same cycle as an advance, including the advance that would detect completion, takes priority: the operation restarts and `done_o` stays 0.
- R13: With all directions enabled, the final image equals a 4-connected flood fill of the mask from the seeded mask pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clear cells, capture images, begin an operation |
| fill_holes_i | input | 1 | Hole-fill option, sampled with start |
| mask_i | input | ROWS*COLS | Foreground mask, 1 = object |
| seed_i | input | ROWS*COLS | Seed (marker) image |
| dir_en_i | input | 4 | Direction gates: N, S, W, E in bits 0..3 |
| free_run_i | input | 1 | 1 = advance every clock |
| step_i | input | 1 | Advance strobe in stepped mode |
| image_o | output | ROWS*COLS | Current reconstructed image |
| done_o | output | 1 | Operation finished |
| iter_o | output | $clog2(ROWS*COLS+1) | Count of advances that changed a cell |

## Verification
The two functions that can meet in one cycle are a restart and the advance that finds no change and would end the operation. The bench repeats one operation many times. On each repeat it moves the restart one cycle later, so one repeat places the start exactly on the completion edge. Another places it on an ordinary growth step. A behavioural model that gives start priority predicts every cycle, and the image, flag and count are compared against it on each clock. A completion flag that appears, or a count that does not clear, is reported as a mismatch.

// File: rtl/geo_pkg.sv
package geo_pkg;
   // direction gate bit positions
   localparam int DIR_N = 0;
   localparam int DIR_S = 1;
   localparam int DIR_W = 2;
   localparam int DIR_E = 3;
   localparam int DIR_W_BITS = 4;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_t;
endpackage

// File: rtl/geo_cell.sv
module geo_cell
   import geo_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  adv,
   input  logic                  mask,
   input  logic                  seed,
   input  logic                  from_n,
   input  logic                  from_s,
   input  logic                  from_w,
   input  logic                  from_e,
   input  logic [DIR_W_BITS-1:0] dir_en,
   output logic                  q,
   output logic                  nxt
);
   logic trig;

   always_comb begin
      trig = seed
           | (from_n & dir_en[DIR_N])
           | (from_s & dir_en[DIR_S])
           | (from_w & dir_en[DIR_W])
           | (from_e & dir_en[DIR_E]);
      nxt  = q | (mask & trig);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else if (clr)
         q <= 1'b0;
      else if (adv)
         q <= nxt;
   end

   // R5
   mono_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr) |=> q);

   // R4
   set_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q) |-> mask);
endmodule

// File: rtl/geo_seed_gen.sv
module geo_seed_gen #(
   parameter int ROWS = 8,
   parameter int COLS = 8,
   localparam int NCELL = ROWS * COLS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             hole_i,
   input  logic [NCELL-1:0] mask_i,
   input  logic [NCELL-1:0] seed_i,
   output logic [NCELL-1:0] mask_q,
   output logic [NCELL-1:0] seed_q,
   output logic             hole_q
);
   logic [NCELL-1:0] border;
   logic [NCELL-1:0] mask_eff;
   logic [NCELL-1:0] seed_eff;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int IDX = r * COLS + c;
         if (r == 0 || r == ROWS - 1 || c == 0 || c == COLS - 1) begin : g_edge
            assign border[IDX] = 1'b1;
         end else begin : g_inner
            assign border[IDX] = 1'b0;
         end
      end
   end

   assign mask_eff = hole_i ? ~mask_i : mask_i;
   assign seed_eff = hole_i ? border  : seed_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         seed_q <= '0;
         hole_q <= 1'b0;
      end else if (load) begin
         mask_q <= mask_eff;
         seed_q <= seed_eff;
         hole_q <= hole_i;
      end
   end
endmodule

// File: rtl/geo_run_ctrl.sv
module geo_run_ctrl
   import geo_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             free_run,
   input  logic             step,
   input  logic             changed,
   output logic             clr,
   output logic             adv,
   output logic             done_o,
   output logic [CNT_W-1:0] iter_o
);
   phase_t phase;

   assign clr = start;
   assign adv = (phase == PH_RUN) && !start && (free_run || step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         done_o <= 1'b0;
         iter_o <= '0;
      end else if (start) begin
         phase  <= PH_RUN;
         done_o <= 1'b0;
         iter_o <= '0;
      end else if (adv) begin
         if (changed) begin
            iter_o <= iter_o + 1'b1;
         end else begin
            phase  <= PH_IDLE;
            done_o <= 1'b1;
         end
      end
   end

   // R10
   done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start) |=> ($stable(iter_o) && done_o));

   // R12
   start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done_o && iter_o == '0));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !free_run && !step) |=> $stable(iter_o));
endmodule

// File: rtl/geo_recon_array.sv
module geo_recon_array
   import geo_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 8,
   localparam int NCELL = ROWS * COLS,
   localparam int CNT_W = $clog2(NCELL + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  fill_holes_i,
   input  logic [NCELL-1:0]      mask_i,
   input  logic [NCELL-1:0]      seed_i,
   input  logic [DIR_W_BITS-1:0] dir_en_i,
   input  logic                  free_run_i,
   input  logic                  step_i,
   output logic [NCELL-1:0]      image_o,
   output logic                  done_o,
   output logic [CNT_W-1:0]      iter_o
);
   if (ROWS < 2) begin : g_bad_rows
      $error("geo_recon_array: ROWS must be at least 2");
   end
   if (COLS < 2) begin : g_bad_cols
      $error("geo_recon_array: COLS must be at least 2");
   end
   if (NCELL > 4096) begin : g_bad_size
      $error("geo_recon_array: array too large");
   end

   logic [NCELL-1:0] mask_q;
   logic [NCELL-1:0] seed_q;
   logic             hole_q;
   logic [NCELL-1:0] state;
   logic [NCELL-1:0] state_nxt;
   logic             clr;
   logic             adv;
   logic             changed;

   geo_seed_gen #(.ROWS(ROWS), .COLS(COLS)) seed_i0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start_i),
      .hole_i (fill_holes_i),
      .mask_i (mask_i),
      .seed_i (seed_i),
      .mask_q (mask_q),
      .seed_q (seed_q),
      .hole_q (hole_q)
   );

   geo_run_ctrl #(.CNT_W(CNT_W)) ctrl_i0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_i),
      .free_run (free_run_i),
      .step     (step_i),
      .changed  (changed),
      .clr      (clr),
      .adv      (adv),
      .done_o   (done_o),
      .iter_o   (iter_o)
   );

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int IDX = r * COLS + c;
         logic nb_n, nb_s, nb_w, nb_e;

         if (r > 0) begin : g_n
            assign nb_n = state[IDX-COLS];
         end else begin : g_n0
            assign nb_n = 1'b0;
         end
         if (r < ROWS - 1) begin : g_s
            assign nb_s = state[IDX+COLS];
         end else begin : g_s0
            assign nb_s = 1'b0;
         end
         if (c > 0) begin : g_w
            assign nb_w = state[IDX-1];
         end else begin : g_w0
            assign nb_w = 1'b0;
         end
         if (c < COLS - 1) begin : g_e
            assign nb_e = state[IDX+1];
         end else begin : g_e0
            assign nb_e = 1'b0;
         end

         geo_cell cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .adv    (adv),
            .mask   (mask_q[IDX]),
            .seed   (seed_q[IDX]),
            .from_n (nb_n),
            .from_s (nb_s),
            .from_w (nb_w),
            .from_e (nb_e),
            .dir_en (dir_en_i),
            .q      (state[IDX]),
            .nxt    (state_nxt[IDX])
         );
      end
   end

   assign changed = |(state_nxt ^ state);
   assign image_o = hole_q ? ~state : state;

   // R8
   step_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !free_run_i && !step_i) |=> $stable(state));

   // R2
   clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (state == '0));
endmodule

// File: tb/geo_recon_array_tb_top.sv
`timescale 1ns/1ps
module geo_recon_array_tb_top;
   localparam int R  = 8;
   localparam int C  = 8;
   localparam int N  = R * C;
   localparam int CW = $clog2(N + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          fill_holes_i = 1'b0;
   logic [N-1:0]  mask_i = '0;
   logic [N-1:0]  seed_i = '0;
   logic [3:0]    dir_en_i = 4'hF;
   logic          free_run_i = 1'b1;
   logic          step_i = 1'b0;
   logic [N-1:0]  image_o;
   logic          done_o;
   logic [CW-1:0] iter_o;

   always #2 clk = ~clk;

   geo_recon_array #(.ROWS(R), .COLS(C)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .fill_holes_i(fill_holes_i),
      .mask_i(mask_i), .seed_i(seed_i), .dir_en_i(dir_en_i),
      .free_run_i(free_run_i), .step_i(step_i),
      .image_o(image_o), .done_o(done_o), .iter_o(iter_o)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   string cur_req = "R1";
   bit    finished = 0;

   // behavioural reference
   bit m_st  [R][C];
   bit m_msk [R][C];
   bit m_sd  [R][C];
   bit m_hole, m_run, m_done;
   int m_cnt;

   function automatic bit m_at(int r, int c);
      if (r < 0 || r >= R || c < 0 || c >= C) return 1'b0;
      return m_st[r][c];
   endfunction

   function automatic logic [N-1:0] m_img();
      logic [N-1:0] v;
      for (int r = 0; r < R; r++)
         for (int c = 0; c < C; c++)
            v[r*C+c] = m_hole ? !m_st[r][c] : m_st[r][c];
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_st[r, c]) m_st[r][c] = 0;
         m_hole = 0; m_run = 0; m_done = 0; m_cnt = 0;
      end else if (start_i) begin
         for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
               bit edge_b;
               edge_b = (r == 0) || (r == R-1) || (c == 0) || (c == C-1);
               m_st[r][c]  = 0;
               m_msk[r][c] = fill_holes_i ? !mask_i[r*C+c] : mask_i[r*C+c];
               m_sd[r][c]  = fill_holes_i ? edge_b : seed_i[r*C+c];
            end
         m_hole = fill_holes_i; m_run = 1; m_done = 0; m_cnt = 0;
      end else if (m_run && (free_run_i || step_i)) begin
         bit nx [R][C];
         bit any;
         any = 0;
         for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
               bit hit;
               hit = m_sd[r][c]
                   || (dir_en_i[0] && m_at(r-1, c))
                   || (dir_en_i[1] && m_at(r+1, c))
                   || (dir_en_i[2] && m_at(r, c-1))
                   || (dir_en_i[3] && m_at(r, c+1));
               nx[r][c] = m_st[r][c] || (m_msk[r][c] && hit);
               if (nx[r][c] != m_st[r][c]) any = 1;
            end
         if (any) begin
            foreach (nx[r, c]) m_st[r][c] = nx[r][c];
            m_cnt++;
         end else begin
            m_run = 0; m_done = 1;
         end
      end
   end

   task automatic check(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n && !finished) begin
         check(cur_req, "image", image_o, m_img());
         check(cur_req, "done", {{(N-1){1'b0}}, done_o}, {{(N-1){1'b0}}, m_done});
         check(cur_req, "iter", {{(N-CW){1'b0}}, iter_o}, N'(m_cnt));
      end
      if (cyc > 150000 && !finished) begin
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   function automatic logic [N-1:0] flood(logic [N-1:0] msk, logic [N-1:0] sd);
      logic [N-1:0] vis;
      int q[$];
      vis = '0;
      for (int i = 0; i < N; i++)
         if (msk[i] && sd[i]) begin vis[i] = 1'b1; q.push_back(i); end
      while (q.size() > 0) begin
         int p, r, c;
         p = q.pop_front(); r = p / C; c = p % C;
         if (r > 0   && msk[p-C] && !vis[p-C]) begin vis[p-C] = 1'b1; q.push_back(p-C); end
         if (r < R-1 && msk[p+C] && !vis[p+C]) begin vis[p+C] = 1'b1; q.push_back(p+C); end
         if (c > 0   && msk[p-1] && !vis[p-1]) begin vis[p-1] = 1'b1; q.push_back(p-1); end
         if (c < C-1 && msk[p+1] && !vis[p+1]) begin vis[p+1] = 1'b1; q.push_back(p+1); end
      end
      return vis;
   endfunction

   task automatic launch(logic [N-1:0] m, logic [N-1:0] s, bit hole);
      @(negedge clk);
      mask_i = m; seed_i = s; fill_holes_i = hole; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(string req);
      int k;
      k = 0;
      while (!done_o && k < 500) begin
         @(negedge clk);
         step_i = (!free_run_i) ? ((k % 3) == 1) : 1'b0;
         k++;
      end
      step_i = 1'b0;
      if (!done_o) begin
         n_bad++;
         $display("FAIL %s completion: actual done=0 expected done=1", req);
      end
   endtask

   localparam logic [N-1:0] IMG_TWO  = 64'h00E0A0E000070507;
   localparam logic [N-1:0] IMG_RING = 64'h0000001C141C0000;
   localparam logic [N-1:0] IMG_FULL = {N{1'b1}};

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "reset image", image_o, '0);
      check("R1", "reset flags", {{(N-1-CW){1'b0}}, done_o, iter_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R13: two objects, seed in the upper-left one
      cur_req = "R3";
      launch(IMG_TWO, 64'h1, 1'b0);
      check("R2", "cleared after start", image_o, '0);
      wait_done("R10");
      @(negedge clk);
      check("R13", "flood fill", image_o, flood(IMG_TWO, 64'h1));

      // R10 empty seed: done after one advance, count 0
      cur_req = "R10";
      launch(IMG_TWO, '0, 1'b0);
      wait_done("R10");
      check("R10", "empty seed count", {{(N-CW){1'b0}}, iter_o}, '0);

      // R4 seed on background pixel
      cur_req = "R4";
      launch(IMG_TWO, 64'h8, 1'b0);
      wait_done("R4");
      check("R4", "background seed", image_o, '0);

      // R6 R9 multiple seeds, full mask, corner seeds: no wrap, free-running
      cur_req = "R6";
      launch(IMG_FULL, 64'h8000000000000001, 1'b0);
      wait_done("R9");
      check("R9", "full mask fill", image_o, IMG_FULL);
      check("R9", "full mask iter", {{(N-CW){1'b0}}, iter_o}, N'(8));

      // R8 stepped mode
      cur_req = "R8";
      free_run_i = 1'b0;
      launch(IMG_TWO, 64'h0020000000000000, 1'b0);
      repeat (4) @(negedge clk);
      wait_done("R8");
      @(negedge clk);
      check("R13", "stepped flood", image_o, flood(IMG_TWO, 64'h0020000000000000));
      free_run_i = 1'b1;

      // R7 only eastward arrival (from east neighbour) and from south
      cur_req = "R7";
      dir_en_i = 4'b1000;
      launch(IMG_FULL, 64'h0000000000000080 << 24, 1'b0);
      wait_done("R7");
      check("R7", "east gate row", image_o, 64'h00000000FF000000);
      dir_en_i = 4'b0010;
      launch(IMG_FULL, 64'h0000000000000008 << 56, 1'b0);
      wait_done("R7");
      check("R7", "south gate column", image_o, 64'h0808080808080808);
      dir_en_i = 4'hF;

      // R11 hole fill of a ring
      cur_req = "R11";
      launch(IMG_RING, '0, 1'b1);
      check("R11", "hole mode after start", image_o, IMG_FULL);
      wait_done("R11");
      check("R11", "hole filled", image_o, 64'h0000001C1C1C0000);
      launch(IMG_TWO, '0, 1'b1);
      wait_done("R11");
      check("R11", "objects with holes filled", image_o, 64'h00E0E0E000070707);

      // R12 restart sliding across the completion edge
      cur_req = "R12";
      for (int off = 0; off < 12; off++) begin
         launch(IMG_TWO, 64'h1, 1'b0);
         repeat (off) @(negedge clk);
         launch(IMG_TWO, 64'h1, 1'b0);
         wait_done("R12");
      end
      check("R12", "final after restarts", image_o, flood(IMG_TWO, 64'h1));

      // R5 hold after done across idle cycles
      cur_req = "R5";
      repeat (5) @(negedge clk);
      check("R5", "held image", image_o, flood(IMG_TWO, 64'h1));

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule